// File: doc/BRIEF.md
# PUF Key Regenerator with Golay Decoding

This block rebuilds a secret key from two inputs. The first is helper data that may be stored in public. The second is a fresh readout of a physically unclonable function (PUF), presented here as a plain input vector. At enrollment the key was cut into 12-bit pieces. Each piece was encoded as a 23-bit binary Golay codeword and masked with the PUF response, and that masked stream is the helper data. To regenerate, the block XORs the helper data with the current PUF readout, which leaves a codeword stream with a few flipped bits. It then decodes the stream one codeword per clock cycle and packs the recovered 12-bit pieces into the key.

Each word is decoded by computing an 11-bit remainder against the code's generator polynomial. That remainder selects a correction pattern from a 2048-entry table, which is computed when the design is elaborated. Every regeneration takes the same number of cycles, whatever the error count. The key leaves only on its own point-to-point output and reads as zero until decoding has finished. Once a key has been reproduced, the block refuses any further start until the next reset.

Top module: `puf_keyregen`

## Requirements
- R1: When `start_i` is seen in the idle state, the block captures `helper_i ^ puf_i`. Codeword i occupies bits [23i+22:23i]. Within a codeword, bits [22:11] carry the 12 message bits and bits [10:0] carry the parity, which is the message times x^11 modulo g(x) = x^11+x^10+x^6+x^5+x^4+x^2+1. Message bit b of codeword i becomes key bit 12i+b.
- R2: Any pattern of 0 to 3 flipped bits within each 23-bit codeword is corrected, and `key_o` equals the enrolled key exactly.
- R3: Message bits of the last codeword at key positions KEY_W and above are padding. Their values do not affect `key_o`.
- R4: `done_o` is a one-cycle pulse. It is high in the cycle after the clock edge that comes NWORDS edges after the edge that accepted `start_i`. This latency does not change with the error count.
- R5: `key_valid_o` rises together with `done_o` and stays high until reset. Whenever `key_valid_o` is low, `key_o` is all zeros.
- R6: After a key has been reproduced, `start_i` is ignored until reset: no busy, no done, and `key_o` keeps its value. A `start_i` that stays high while decoding runs has no effect either.
- R7: While `rst` is high and after it falls, `key_valid_o`, `done_o` and `busy_o` are low and `key_o` is zero.
- R8: `busy_o` is high for exactly NWORDS cycles per regeneration and is never high together with `key_valid_o`.
- R9: `helper_i` and `puf_i` are sampled only on the edge that accepts the start. Changes on them during decoding do not alter the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one regeneration (honoured once per reset) |
| helper_i | input | STREAM_W (506) | Public helper data, NWORDS codewords of 23 bits |
| puf_i | input | STREAM_W (506) | PUF response readout |
| key_o | output | KEY_W (256) | Recovered key, zero until valid |
| key_valid_o | output | 1 | Key valid, held until reset |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Decoding in progress |

## Verification
The bench builds the block with the default KEY_W of 256. That gives 22 codewords, and the last one carries only 4 key bits plus 8 padding bits, so the padding-discard path is exercised. Random keys and PUF vectors are combined with 0 to 3 random bit flips per codeword, and the bench checks for exact recovery together with an unchanged latency. Separate cases fill the padding with ones, change the inputs while decoding runs, hold start high throughout, and retry start once the block has locked.

// File: rtl/golay_pkg.sv
package golay_pkg;

    localparam int CW_W  = 23;
    localparam int MSG_W = 12;
    localparam int SYN_W = 11;
    localparam int TAB_N = 2048;
    // generator x^11+x^10+x^6+x^5+x^4+x^2+1 without its leading term
    localparam logic [SYN_W-1:0] GEN_LO = 11'h475;

    typedef logic [CW_W-1:0]  cw_t;
    typedef logic [MSG_W-1:0] msg_t;
    typedef logic [SYN_W-1:0] syn_t;
    typedef cw_t etab_t [TAB_N];

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_LOCK
    } rg_state_e;

    // Bit-serial remainder modulo the generator, highest coefficient first
    function automatic syn_t cw_rem(cw_t w);
        syn_t r;
        logic fb;
        r = '0;
        for (int j = CW_W - 1; j >= 0; j--) begin
            fb = r[SYN_W-1];
            r  = {r[SYN_W-2:0], w[j]};
            if (fb) r = r ^ GEN_LO;
        end
        return r;
    endfunction

    // Correction table: every pattern of weight 0..3 stored at its remainder
    function automatic etab_t build_etab();
        etab_t t;
        cw_t   e;
        t = '{default: '0};
        for (int i = 0; i < CW_W; i++) begin
            e = cw_t'(1) << i;
            t[cw_rem(e)] = e;
            for (int j = i + 1; j < CW_W; j++) begin
                e = (cw_t'(1) << i) | (cw_t'(1) << j);
                t[cw_rem(e)] = e;
                for (int k = j + 1; k < CW_W; k++) begin
                    e = (cw_t'(1) << i) | (cw_t'(1) << j) | (cw_t'(1) << k);
                    t[cw_rem(e)] = e;
                end
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/golay_word_dec.sv
module golay_word_dec
    import golay_pkg::*;
(
    input  cw_t  rx_i,
    output msg_t msg_o
);
    localparam etab_t ETAB = build_etab();

    syn_t syn;
    cw_t  fixed;

    always_comb begin
        syn   = cw_rem(rx_i);
        fixed = rx_i ^ ETAB[syn];
        msg_o = fixed[CW_W-1:CW_W-MSG_W];
    end
endmodule

// File: rtl/regen_ctrl.sv
module regen_ctrl
    import golay_pkg::*;
#(
    parameter int NWORDS = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic done_o,
    output logic locked_o
);
    localparam int IDX_W = $clog2(NWORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

    rg_state_e        st_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;

    assign load_o   = (st_q == ST_IDLE) && start_i;
    assign step_o   = (st_q == ST_RUN);
    assign locked_o = (st_q == ST_LOCK);
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q  <= ST_RUN;
                        idx_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (idx_q == LAST) begin
                        st_q   <= ST_LOCK;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: st_q <= ST_LOCK;
            endcase
        end
    end
endmodule

// File: rtl/puf_keyregen.sv
module puf_keyregen
    import golay_pkg::*;
#(
    parameter int KEY_W = 256,
    localparam int NWORDS   = (KEY_W + MSG_W - 1) / MSG_W,
    localparam int STREAM_W = NWORDS * CW_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [STREAM_W-1:0] helper_i,
    input  logic [STREAM_W-1:0] puf_i,
    output logic [KEY_W-1:0]    key_o,
    output logic                key_valid_o,
    output logic                done_o,
    output logic                busy_o
);
    localparam int PACK_W = NWORDS * MSG_W;

    logic                load, step, locked;
    logic [STREAM_W-1:0] stream_q;
    logic [PACK_W-1:0]   acc_q;
    msg_t                msg;

    regen_ctrl #(.NWORDS(NWORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .load_o   (load),
        .step_o   (step),
        .done_o   (done_o),
        .locked_o (locked)
    );

    golay_word_dec u_dec (
        .rx_i  (stream_q[CW_W-1:0]),
        .msg_o (msg)
    );

    // Codeword stream drains from the bottom; message pieces fill from the top
    always_ff @(posedge clk) begin
        if (rst) begin
            stream_q <= '0;
            acc_q    <= '0;
        end else if (load) begin
            stream_q <= helper_i ^ puf_i;
        end else if (step) begin
            stream_q <= {CW_W'(0), stream_q[STREAM_W-1:CW_W]};
            acc_q    <= {msg, acc_q[PACK_W-1:MSG_W]};
        end
    end

    assign busy_o      = step;
    assign key_valid_o = locked;
    assign key_o       = locked ? acc_q[KEY_W-1:0] : '0;
endmodule

// File: rtl/regen_chk.sv
module regen_chk #(
    parameter int NWORDS = 22,
    parameter int KEY_W  = 256
) (
    input logic             clk,
    input logic             rst,
    input logic [KEY_W-1:0] key_o,
    input logic             key_valid_o,
    input logic             done_o,
    input logic             busy_o
);
    logic [15:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 16'd1;
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r4_const_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_cnt == 16'(NWORDS)));

    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |=> key_valid_o);

    a_r5_key_hidden: assert property (@(posedge clk) disable iff (rst)
        !key_valid_o |-> (key_o == '0));

    a_r5_done_with_valid: assert property (@(posedge clk) disable iff (rst)
        done_o |-> key_valid_o);

    a_r6_locked_quiet: assert property (@(posedge clk) disable iff (rst)
        key_valid_o |=> (!busy_o && $stable(key_o)));

    a_r8_busy_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && key_valid_o));
endmodule

bind puf_keyregen regen_chk #(.NWORDS(NWORDS), .KEY_W(KEY_W)) u_regen_chk (
    .clk         (clk),
    .rst         (rst),
    .key_o       (key_o),
    .key_valid_o (key_valid_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
);

// File: tb/test_puf_keyregen.sv
`timescale 1ns/1ps
module test_puf_keyregen;
    localparam int KEY_W  = 256;
    localparam int NW     = 22;
    localparam int SW     = NW * 23;
    localparam int NVEC   = 6;

    localparam logic [255:0] VKEY [NVEC] = '{
        256'h0,
        {256{1'b1}},
        {8{32'hDEADBEEF}},
        {4{64'h0123456789ABCDEF}},
        {16{16'hA55A}},
        {2{128'hF00D_CAFE_1357_9BDF_2468_ACE0_8642_FDB9}}
    };
    localparam int VERR [NVEC] = '{0, 1, 2, 3, 3, 3};
    localparam bit VHOLD [NVEC] = '{0, 0, 0, 1, 0, 0};
    localparam bit VPAD  [NVEC] = '{0, 0, 0, 0, 1, 0};
    localparam bit VSCR  [NVEC] = '{0, 0, 0, 0, 0, 1};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [SW-1:0]    helper_i = '0;
    logic [SW-1:0]    puf_i = '0;
    logic [KEY_W-1:0] key_o;
    logic             key_valid_o, done_o, busy_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    puf_keyregen #(.KEY_W(KEY_W)) i_puf_keyregen (
        .clk(clk), .rst(rst), .start_i(start_i), .helper_i(helper_i),
        .puf_i(puf_i), .key_o(key_o), .key_valid_o(key_valid_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // parity by long division of m*x^11 by the generator (R1)
    function automatic logic [10:0] parity_of(logic [11:0] m);
        logic [22:0] v;
        v = {m, 11'b0};
        for (int b = 22; b >= 11; b--)
            if (v[b]) v = v ^ (23'hC75 << (b - 11));
        return v[10:0];
    endfunction

    function automatic logic [SW-1:0] encode_key(logic [255:0] k, bit padfill);
        logic [SW-1:0] s;
        logic [11:0]   m;
        s = '0;
        for (int w = 0; w < NW; w++) begin
            for (int b = 0; b < 12; b++)
                m[b] = (w * 12 + b < KEY_W) ? k[w * 12 + b] : padfill;
            s[w * 23 +: 23] = {m, parity_of(m)};
        end
        return s;
    endfunction

    function automatic logic [SW-1:0] err_mask(int nerr);
        logic [SW-1:0] s;
        logic [22:0]   e;
        int            cnt, p;
        s = '0;
        for (int w = 0; w < NW; w++) begin
            e = '0;
            cnt = 0;
            while (cnt < nerr) begin
                p = $urandom_range(22, 0);
                if (!e[p]) begin
                    e[p] = 1'b1;
                    cnt++;
                end
            end
            s[w * 23 +: 23] = e;
        end
        return s;
    endfunction

    function automatic logic [SW-1:0] rand_vec();
        logic [SW-1:0] s;
        for (int i = 0; i < SW; i++) s[i] = 1'($urandom);
        return s;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        start_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R7: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!key_valid_o && !done_o && !busy_o, "R7 flags in reset", {253'b0, key_valid_o, done_o, busy_o}, '0);
        chk(key_o == '0, "R7 key in reset", key_o, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(!key_valid_o && !busy_o && key_o == '0, "R7 after reset", key_o, '0);

        for (int v = 0; v < NVEC; v++) begin
            logic [SW-1:0] puf;
            int            lat, bcnt;
            bit            leak, late_act;
            do_reset();
            puf      = rand_vec();
            puf_i    = puf;
            helper_i = encode_key(VKEY[v], VPAD[v]) ^ puf ^ err_mask(VERR[v]);
            start_i  = 1'b1;
            lat = 0; bcnt = 0; leak = 0;
            do begin
                @(posedge clk);
                lat++;
                @(negedge clk);
                if (!VHOLD[v]) start_i = 1'b0;
                if (VSCR[v]) begin
                    helper_i = rand_vec();
                    puf_i    = rand_vec();
                end
                if (busy_o) bcnt++;
                if (!key_valid_o && key_o != '0) leak = 1;
            end while (!done_o && lat < 100);
            // R2/R1 exact recovery; R3 padding ignored when VPAD; R9 when VSCR
            chk(key_o == VKEY[v], $sformatf("R2 R1 R3 R9 key vec%0d errs=%0d", v, VERR[v]), key_o, VKEY[v]);
            chk(lat == NW + 1, $sformatf("R4 latency vec%0d", v), 256'(lat), 256'(NW + 1));
            chk(bcnt == NW, $sformatf("R8 busy cycles vec%0d", v), 256'(bcnt), 256'(NW));
            chk(key_valid_o && !leak, $sformatf("R5 valid/hidden vec%0d", v), {254'b0, key_valid_o, leak}, 256'b10);
            @(negedge clk);
            chk(!done_o && key_valid_o, $sformatf("R4 R5 pulse ends vec%0d", v), {254'b0, done_o, key_valid_o}, 256'b01);

            // R6: retry after lock with different inputs
            start_i  = 1'b0;
            puf_i    = ~puf;
            helper_i = rand_vec();
            @(negedge clk);
            start_i = 1'b1;
            late_act = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                start_i = 1'b0;
                if (busy_o || done_o || !key_valid_o) late_act = 1;
            end
            chk(!late_act && key_o == VKEY[v], $sformatf("R6 restart ignored vec%0d", v), key_o, VKEY[v]);
        end

        // R7: reset clears a produced key
        do_reset();
        chk(!key_valid_o && key_o == '0, "R7 reset after key", key_o, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule